// File: doc/BRIEF.md
# Split-Access Dual Accumulator File

This block stores two 40-bit accumulators and moves data between them and a 32-bit register path one portion at a time. Each accumulator has a 16-bit low half, a 16-bit high half and an 8-bit extension byte. A write takes a 16-bit value from the register path and places it into one selected portion of one selected accumulator. The other portions and the other accumulator keep their contents. A read returns a 32-bit value for the register-file write port, in one of three forms: the low 32 bits unchanged, the extension sign-extended to 32 bits, or the extension sign-extended to 16 bits and placed under the upper half of a caller-supplied destination value.

Writes take effect on the rising clock edge. Reads are purely combinational from the stored state. Both accumulators can be zeroed with a synchronous clear. A synchronous reset, active high, also zeroes them. The block does no arithmetic, no saturation and no flag generation. It models only register transfers.

Top module: `split_acc_file`

## Requirements
- R1: The block holds two independent 40-bit accumulators, selected by `wr_sel`/`rd_sel` (0 or 1). Bits 39:32 are the extension, 31:16 the high half and 15:0 the low half. A write to one accumulator never changes the other.
- R2: A write with portion code 0 replaces bits 15:0 of the selected accumulator with `wr_data` and leaves bits 39:16 unchanged.
- R3: A write with portion code 1 replaces bits 31:16 with `wr_data` and leaves bits 39:32 and 15:0 unchanged.
- R4: A write with portion code 2 stores only `wr_data[7:0]` into bits 39:32 (0x7717 stores 0x17) and leaves bits 31:0 unchanged.
- R5: A write with portion code 3 changes no accumulator.
- R6: Read mode 0 returns accumulator bits 31:0 unchanged.
- R7: Read mode 1 returns the extension sign-extended from its bit 7 to 32 bits (0x17 gives 0x00000017, 0xD7 gives 0xFFFFFFD7).
- R8: Read mode 2 returns `{rd_merge_base[31:16], ext sign-extended to 16 bits}` (0x15 gives 0x0015, 0xB7 gives 0xFFB7 in the low half).
- R9: Read mode 3 returns zero.
- R10: Reads are combinational. A read in the same cycle as a write to the same portion returns the value held before that write.
- R11: When `clr` is high at a rising edge, all 80 accumulator bits become zero, and any write in that cycle is dropped.
- R12: When `rst` is high at a rising edge, all accumulator bits become zero, and any write in that cycle is dropped.
- R13: While `wr_en` is low, no accumulator changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of both accumulators |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 1 | Accumulator targeted by the write |
| wr_part | input | 2 | Portion code: 0 low, 1 high, 2 extension, 3 none |
| wr_data | input | 16 | Write source value |
| rd_sel | input | 1 | Accumulator targeted by the read |
| rd_mode | input | 2 | Read form: 0 word, 1 ext to 32, 2 ext merged to low half, 3 zero |
| rd_merge_base | input | 32 | Current destination value used by the merge form |
| rd_data | output | 32 | Formatted read result |

## Verification
The bench loads extension bytes with bit 7 both clear and set. A formatter that zero-extends, or that copies the wrong bit as the sign, would return 0x000000D7 where 0xFFFFFFD7 is expected. Merge reads use destination values whose upper half differs from the sign fill, so a design that overwrites or clears the upper half shows up at once. Extension writes use sources whose upper byte is nonzero, which catches a design that stores the wrong byte. Partial writes are followed by word reads, so a design that disturbs the other half, or touches the wrong accumulator, returns a changed neighbour. Finally, clear and reset are raised in the same cycle as a write, and a read is taken before the write edge, which exposes a design that lets the write win or that forwards the new data early.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    localparam int HALF_W = 16;
    localparam int EXT_W  = 8;
    localparam int WORD_W = 2 * HALF_W;
    localparam int ACC_W  = EXT_W + WORD_W;

    typedef enum logic [1:0] {
        PART_LO   = 2'd0,
        PART_HI   = 2'd1,
        PART_EXT  = 2'd2,
        PART_NONE = 2'd3
    } part_e;

    typedef enum logic [1:0] {
        RD_WORD      = 2'd0,
        RD_EXT_FULL  = 2'd1,
        RD_EXT_MERGE = 2'd2,
        RD_ZERO      = 2'd3
    } rdmode_e;

    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } acc_t;

endpackage

// File: rtl/acc_wr_decode.sv
module acc_wr_decode
    import sacc_pkg::*;
#(
    parameter int NUM_ACC = 2,
    parameter int SEL_W   = 1
) (
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [1:0]         wr_part,
    output logic [NUM_ACC-1:0] lo_we,
    output logic [NUM_ACC-1:0] hi_we,
    output logic [NUM_ACC-1:0] ext_we
);

    part_e part;
    assign part = part_e'(wr_part);

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_strobe
        logic hit;
        assign hit       = wr_en && (wr_sel == SEL_W'(i));
        assign lo_we[i]  = hit && (part == PART_LO);
        assign hi_we[i]  = hit && (part == PART_HI);
        assign ext_we[i] = hit && (part == PART_EXT);
    end

endmodule

// File: rtl/acc_slice.sv
module acc_slice
    import sacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              ext_we,
    input  logic [HALF_W-1:0] wr_data,
    output acc_t              acc_q
);

    acc_t acc_d;

    always_comb begin
        acc_d = acc_q;
        if (lo_we) begin
            acc_d.lo = wr_data;
        end
        if (hi_we) begin
            acc_d.hi = wr_data;
        end
        if (ext_we) begin
            acc_d.ext = wr_data[EXT_W-1:0];
        end
        if (rst || clr) begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

endmodule

// File: rtl/acc_rd_format.sv
module acc_rd_format
    import sacc_pkg::*;
#(
    parameter int NUM_ACC = 2,
    parameter int SEL_W   = 1
) (
    input  logic [NUM_ACC*ACC_W-1:0] acc_flat,
    input  logic [SEL_W-1:0]         rd_sel,
    input  logic [1:0]               rd_mode,
    input  logic [WORD_W-1:0]        merge_base,
    output logic [WORD_W-1:0]        rd_data
);

    acc_t accs [NUM_ACC];

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_unpack
        assign accs[i] = acc_t'(acc_flat[i*ACC_W +: ACC_W]);
    end

    acc_t               pick;
    logic [WORD_W-1:0]  ext_full;
    logic [HALF_W-1:0]  ext_half;

    always_comb begin
        pick = '0;
        for (int k = 0; k < NUM_ACC; k++) begin
            if (rd_sel == SEL_W'(k)) begin
                pick = accs[k];
            end
        end
        ext_full = {{(WORD_W-EXT_W){pick.ext[EXT_W-1]}}, pick.ext};
        ext_half = {{(HALF_W-EXT_W){pick.ext[EXT_W-1]}}, pick.ext};
        case (rdmode_e'(rd_mode))
            RD_WORD:      rd_data = {pick.hi, pick.lo};
            RD_EXT_FULL:  rd_data = ext_full;
            RD_EXT_MERGE: rd_data = {merge_base[WORD_W-1:HALF_W], ext_half};
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/split_acc_file.sv
module split_acc_file
    import sacc_pkg::*;
#(
    parameter int NUM_ACC = 2,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [1:0]        wr_part,
    input  logic [15:0]       wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [1:0]        rd_mode,
    input  logic [31:0]       rd_merge_base,
    output logic [31:0]       rd_data
);

    logic [NUM_ACC-1:0]       lo_we;
    logic [NUM_ACC-1:0]       hi_we;
    logic [NUM_ACC-1:0]       ext_we;
    logic [NUM_ACC*ACC_W-1:0] acc_flat;

    acc_wr_decode #(
        .NUM_ACC (NUM_ACC),
        .SEL_W   (SEL_W)
    ) i_decode (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_part (wr_part),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .ext_we  (ext_we)
    );

    for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
        acc_t slot_q;

        acc_slice i_slice (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .lo_we   (lo_we[i]),
            .hi_we   (hi_we[i]),
            .ext_we  (ext_we[i]),
            .wr_data (wr_data),
            .acc_q   (slot_q)
        );

        assign acc_flat[i*ACC_W +: ACC_W] = slot_q;
    end

    acc_rd_format #(
        .NUM_ACC (NUM_ACC),
        .SEL_W   (SEL_W)
    ) i_format (
        .acc_flat   (acc_flat),
        .rd_sel     (rd_sel),
        .rd_mode    (rd_mode),
        .merge_base (rd_merge_base),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/split_acc_file_chk.sv
module split_acc_file_chk
    import sacc_pkg::*;
#(
    parameter int NUM_ACC = 2,
    parameter int SEL_W   = 1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     clr,
    input logic                     wr_en,
    input logic [SEL_W-1:0]         wr_sel,
    input logic [1:0]               wr_part,
    input logic [15:0]              wr_data,
    input logic [1:0]               rd_mode,
    input logic [31:0]              rd_merge_base,
    input logic [31:0]              rd_data,
    input logic [NUM_ACC*ACC_W-1:0] acc_flat
);

    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    function automatic acc_t slot(input logic [NUM_ACC*ACC_W-1:0] flat, input int idx);
        return acc_t'(flat[idx*ACC_W +: ACC_W]);
    endfunction

    logic live_wr;
    assign live_wr = wr_en && !clr && !rst;

    p_clear_zero_r11: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(clr) |-> acc_flat == '0);

    p_reset_zero_r12: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(rst) |-> acc_flat == '0);

    p_lo_write_r2: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(live_wr && wr_part == 2'd0) |->
            slot(acc_flat, int'($past(wr_sel))).lo == $past(wr_data) &&
            slot(acc_flat, int'($past(wr_sel))).hi == slot($past(acc_flat), int'($past(wr_sel))).hi &&
            slot(acc_flat, int'($past(wr_sel))).ext == slot($past(acc_flat), int'($past(wr_sel))).ext);

    p_hi_write_r3: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(live_wr && wr_part == 2'd1) |->
            slot(acc_flat, int'($past(wr_sel))).hi == $past(wr_data) &&
            slot(acc_flat, int'($past(wr_sel))).lo == slot($past(acc_flat), int'($past(wr_sel))).lo &&
            slot(acc_flat, int'($past(wr_sel))).ext == slot($past(acc_flat), int'($past(wr_sel))).ext);

    p_ext_write_r4: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(live_wr && wr_part == 2'd2) |->
            slot(acc_flat, int'($past(wr_sel))).ext == $past(wr_data[7:0]) &&
            slot(acc_flat, int'($past(wr_sel))).hi == slot($past(acc_flat), int'($past(wr_sel))).hi &&
            slot(acc_flat, int'($past(wr_sel))).lo == slot($past(acc_flat), int'($past(wr_sel))).lo);

    p_none_part_r5: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(live_wr && wr_part == 2'd3) |-> $stable(acc_flat));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (rst)
        past_valid && $past(!wr_en && !clr && !rst) |-> $stable(acc_flat));

    p_merge_upper_r8: assert property (@(posedge clk) disable iff (rst)
        rd_mode == 2'd2 |-> rd_data[31:16] == rd_merge_base[31:16]);

    p_zero_mode_r9: assert property (@(posedge clk) disable iff (rst)
        rd_mode == 2'd3 |-> rd_data == 32'd0);

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_other
        p_other_acc_r1: assert property (@(posedge clk) disable iff (rst)
            past_valid && $past(!clr && !rst && wr_sel != SEL_W'(k)) |->
                slot(acc_flat, k) == slot($past(acc_flat), k));
    end

endmodule

bind split_acc_file split_acc_file_chk #(
    .NUM_ACC (NUM_ACC),
    .SEL_W   (SEL_W)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_part       (wr_part),
    .wr_data       (wr_data),
    .rd_mode       (rd_mode),
    .rd_merge_base (rd_merge_base),
    .rd_data       (rd_data),
    .acc_flat      (acc_flat)
);

// File: tb/test_split_acc_file.sv
`timescale 1ns/1ps
module test_split_acc_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [1:0]  wr_part = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        rd_sel = 1'b0;
    logic [1:0]  rd_mode = 2'd0;
    logic [31:0] rd_merge_base = 32'd0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    split_acc_file i_split_acc_file (
        .clk           (clk),
        .rst           (rst),
        .clr           (clr),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_part       (wr_part),
        .wr_data       (wr_data),
        .rd_sel        (rd_sel),
        .rd_mode       (rd_mode),
        .rd_merge_base (rd_merge_base),
        .rd_data       (rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [1:0] part, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_part = part; wr_data = data;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input string req, input logic sel, input logic [1:0] mode,
                             input logic [31:0] base, input logic [31:0] exp);
        rd_sel = sel; rd_mode = mode; rd_merge_base = base;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        rd_expect("R12 reset A0 word", 1'b0, 2'd0, 32'h0, 32'h0);
        rd_expect("R12 reset A1 word", 1'b1, 2'd0, 32'h0, 32'h0);
        rd_expect("R12 reset A1 ext", 1'b1, 2'd1, 32'h0, 32'h0);
    endtask

    task automatic t_halves;
        wr(1'b0, 2'd0, 16'h8911);
        wr(1'b0, 2'd1, 16'hA567);
        rd_expect("R6 word read", 1'b0, 2'd0, 32'h0, 32'hA567_8911);
        wr(1'b0, 2'd0, 16'h1234);
        rd_expect("R2 low write keeps high", 1'b0, 2'd0, 32'h0, 32'hA567_1234);
        wr(1'b0, 2'd1, 16'h5A5A);
        rd_expect("R3 high write keeps low", 1'b0, 2'd0, 32'h0, 32'h5A5A_1234);
        rd_expect("R3 high write keeps ext", 1'b0, 2'd1, 32'h0, 32'h0);
    endtask

    task automatic t_ext;
        wr(1'b0, 2'd2, 16'hAB1D);
        rd_expect("R7 positive ext", 1'b0, 2'd1, 32'h0, 32'h0000_001D);
        rd_expect("R8 positive merge", 1'b0, 2'd2, 32'h6789_AE1D, 32'h6789_001D);
        rd_expect("R4 ext write keeps word", 1'b0, 2'd0, 32'h0, 32'h5A5A_1234);
        wr(1'b0, 2'd2, 16'hA7D7);
        rd_expect("R7 negative ext", 1'b0, 2'd1, 32'h0, 32'hFFFF_FFD7);
        rd_expect("R8 negative merge", 1'b0, 2'd2, 32'hB444_5515, 32'hB444_FFD7);
        wr(1'b0, 2'd2, 16'h5515);
        rd_expect("R4 low byte only", 1'b0, 2'd1, 32'h0, 32'h0000_0015);
    endtask

    task automatic t_indep;
        wr(1'b1, 2'd0, 16'hF91B);
        wr(1'b1, 2'd1, 16'hE567);
        wr(1'b1, 2'd2, 16'h7717);
        rd_expect("R1 A1 word", 1'b1, 2'd0, 32'h0, 32'hE567_F91B);
        rd_expect("R1 A1 ext", 1'b1, 2'd1, 32'h0, 32'h0000_0017);
        rd_expect("R8 A1 merge", 1'b1, 2'd2, 32'hD4B4_5515, 32'hD4B4_0017);
        rd_expect("R1 A0 word untouched", 1'b0, 2'd0, 32'h0, 32'h5A5A_1234);
        rd_expect("R1 A0 ext untouched", 1'b0, 2'd1, 32'h0, 32'h0000_0015);
    endtask

    task automatic t_bad_part;
        wr(1'b0, 2'd3, 16'hFFFF);
        rd_expect("R5 A0 word", 1'b0, 2'd0, 32'h0, 32'h5A5A_1234);
        rd_expect("R5 A0 ext", 1'b0, 2'd1, 32'h0, 32'h0000_0015);
        rd_expect("R5 A1 word", 1'b1, 2'd0, 32'h0, 32'hE567_F91B);
    endtask

    task automatic t_no_en;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 1'b1; wr_part = 2'd1; wr_data = 16'hDEAD;
        @(posedge clk);
        #1;
        rd_expect("R13 disabled write", 1'b1, 2'd0, 32'h0, 32'hE567_F91B);
    endtask

    task automatic t_mode3;
        rd_expect("R9 zero mode A0", 1'b0, 2'd3, 32'hFFFF_FFFF, 32'h0);
        rd_expect("R9 zero mode A1", 1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0);
    endtask

    task automatic t_bypass;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_part = 2'd0; wr_data = 16'hBEEF;
        rd_expect("R10 old value before edge", 1'b1, 2'd0, 32'h0, 32'hE567_F91B);
        @(posedge clk);
        #1 wr_en = 1'b0;
        rd_expect("R10 new value after edge", 1'b1, 2'd0, 32'h0, 32'hE567_BEEF);
    endtask

    task automatic t_clear;
        @(negedge clk);
        clr = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_part = 2'd1; wr_data = 16'h7777;
        @(posedge clk);
        #1 clr = 1'b0; wr_en = 1'b0;
        rd_expect("R11 A0 word cleared", 1'b0, 2'd0, 32'h0, 32'h0);
        rd_expect("R11 A0 ext cleared", 1'b0, 2'd1, 32'h0, 32'h0);
        rd_expect("R11 A1 word cleared", 1'b1, 2'd0, 32'h0, 32'h0);
        rd_expect("R11 A1 ext cleared", 1'b1, 2'd2, 32'hC3C3_0000, 32'hC3C3_0000);
    endtask

    task automatic t_reset_prio;
        wr(1'b1, 2'd2, 16'h00C8);
        rd_expect("R4 ext before reset", 1'b1, 2'd1, 32'h0, 32'hFFFF_FFC8);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_part = 2'd0; wr_data = 16'h4321;
        @(posedge clk);
        #1 rst = 1'b0; wr_en = 1'b0;
        rd_expect("R12 reset beats write word", 1'b1, 2'd0, 32'h0, 32'h0);
        rd_expect("R12 reset beats write ext", 1'b1, 2'd1, 32'h0, 32'h0);
    endtask

    initial begin
        t_reset;
        t_halves;
        t_ext;
        t_indep;
        t_bad_part;
        t_no_en;
        t_mode3;
        t_bypass;
        t_clear;
        t_reset_prio;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule